// File: doc/BRIEF.md
# Run-Length Pulse Sequence Transmitter

This block plays a list of timed output levels onto one pin. A host fills a small word memory, where each 32-bit word carries two 16-bit items. An item names a pin level and how many prescaled ticks that level lasts. After a start pulse the block walks the items in order and drives the pin, one item after the other, with no gap between them. An item whose duration is zero marks the end of the list.

At the end marker the block either stops and drives its idle level, or, in continuous mode, jumps back to word 0 and keeps going. The host can refill memory while playback runs. A word counter raises a threshold event when a set number of whole words has been played, and the end of a one-shot run raises an end event. Both events are sticky status bits, cleared by writing ones, and an enable mask selects which of them drive the interrupt line.

The playback mode, the threshold limit and the idle settings are written into a shadow bank. They take effect only on a configuration-update pulse. A pointer-reset input sends playback back to the first item without touching memory.

Top module: `pulse_seq_tx`

## Requirements
- R1: Each 16-bit item holds the pin level in bit 15 and a duration in bits 14:0. One tick is PRESCALE (default 5) clock cycles, and an item with duration D drives its level for exactly D*PRESCALE cycles.
- R2: A tx_start pulse begins playback at word 0 from the first cycle after the pulse. Inside a word the low half (bits 15:0) plays before the high half (bits 31:16), and words play in ascending address order.
- R3: An item whose duration is zero is an end marker. It takes no time: what follows it starts on the clock edge at which the last tick of the item before it ends.
- R4: With continuous mode active, reaching the end marker restarts playback at word 0, low half, and the end status bit is not set.
- R5: With continuous mode inactive, reaching the end marker stops playback, the pin returns to its idle value, and end status (bit 0) is set on that same edge.
- R6: Register 64 holds the shadow settings: bit 0 continuous, bit 1 idle level, bit 2 idle enable. Register 65 holds the shadow threshold limit. These settings reach the active set only on a cfg_update pulse. tx_start works without that pulse.
- R7: Threshold status (bit 1) is set on the edge at which the count of whole words played since the start, the last pointer reset or the last wrap becomes equal to the active limit. A newly written and updated limit arms the next hit.
- R8: Status bits stay set until a 1 is written to the same bit of register 67. Register 66 is an enable mask, and irq is high whenever an enabled status bit is set.
- R9: An rd_rst pulse during playback restarts at word 0, low half, with a fresh tick count. Playback keeps running and memory is left unchanged.
- R10: When not playing, the pin drives the idle level if idle enable is set and 0 otherwise. After reset all settings, the mask and the status are 0.
- R11: Addresses 0 to MEM_WORDS-1 (default 48) write the item memory at any time. The read pointer stays below MEM_WORDS and wraps from the last word to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | $clog2(MEM_WORDS)+1 | Host write address (memory below 64, registers from 64) |
| host_wdata | input | 32 | Host write data |
| cfg_update | input | 1 | Copies the shadow settings into the active set |
| tx_start | input | 1 | Starts playback at word 0 |
| rd_rst | input | 1 | Returns playback to word 0 without stopping it |
| pin_out | output | 1 | Sequenced output pin |
| irq | output | 1 | Enabled status present |
| irq_status | output | 2 | Sticky status: bit 0 end, bit 1 threshold |

## Verification
One-shot playback is swept over eight item lists of growing length. Durations and levels vary, and the end marker falls in both the low and the high half of a word. This separates half-ordering errors, tick-length errors and end-marker timing errors cycle by cycle.

Continuous runs check that the sequence repeats without gaps, and that clearing the mode ends the run after the current pass only once the update pulse arrives. Threshold runs with two different limits show whether the event fires on the exact word boundary and whether re-arming works. A pointer reset in the middle of an item must reproduce the whole sequence from the start, which also shows that memory was left intact.

// File: rtl/pst_pkg.sv
package pst_pkg;
    // register offsets above the memory window
    localparam int OFS_CONF  = 0;
    localparam int OFS_LIMIT = 1;
    localparam int OFS_ENA   = 2;
    localparam int OFS_CLR   = 3;

    // bits of the configuration register
    localparam int CONF_CONT     = 0;
    localparam int CONF_IDLE_LVL = 1;
    localparam int CONF_IDLE_EN  = 2;

    // status bit positions
    localparam int ST_END = 0;
    localparam int ST_THR = 1;

    // item layout
    localparam int ITEM_W     = 16;
    localparam int ITEM_DUR_W = 15;
endpackage

// File: rtl/pst_tick_gen.sv
module pst_tick_gen #(
    parameter int PRESCALE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && !clr && (cnt_q == LAST);
endmodule

// File: rtl/pst_item_mem.sv
module pst_item_mem #(
    parameter int WORDS = 48
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [$clog2(WORDS)-1:0]              waddr,
    input  logic [31:0]                           wdata,
    input  logic [$clog2(WORDS)-1:0]              ra_a,
    input  logic                                  ra_a_hi,
    output logic [pst_pkg::ITEM_W-1:0]            item_a,
    input  logic [$clog2(WORDS)-1:0]              ra_b,
    input  logic                                  ra_b_hi,
    output logic [pst_pkg::ITEM_DUR_W-1:0]        dur_b
);
    import pst_pkg::*;

    logic [31:0] mem_q [WORDS];
    logic [31:0] word_a, word_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign word_a = mem_q[ra_a];
    assign word_b = mem_q[ra_b];
    assign item_a = ra_a_hi ? word_a[31:16] : word_a[15:0];
    assign dur_b  = ra_b_hi ? word_b[16+ITEM_DUR_W-1:16] : word_b[ITEM_DUR_W-1:0];
endmodule

// File: rtl/pst_cfg_regs.sv
module pst_cfg_regs #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              update,
    output logic              cont_act,
    output logic              idle_lvl_act,
    output logic              idle_en_act,
    output logic [CNT_W-1:0]  limit_act,
    output logic [1:0]        irq_ena,
    output logic [1:0]        clr_mask
);
    import pst_pkg::*;

    localparam int REG_BASE = 1 << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] A_CONF  = ADDR_W'(REG_BASE + OFS_CONF);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(REG_BASE + OFS_LIMIT);
    localparam logic [ADDR_W-1:0] A_ENA   = ADDR_W'(REG_BASE + OFS_ENA);
    localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(REG_BASE + OFS_CLR);

    typedef struct packed {
        logic [2:0]       conf_sh;
        logic [CNT_W-1:0] limit_sh;
        logic [2:0]       conf_act;
        logic [CNT_W-1:0] limit_act;
        logic [1:0]       ena;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && addr == A_CONF)  cfg_d.conf_sh  = wdata[2:0];
        if (we && addr == A_LIMIT) cfg_d.limit_sh = wdata;
        if (we && addr == A_ENA)   cfg_d.ena      = wdata[1:0];
        if (update) begin
            cfg_d.conf_act  = cfg_q.conf_sh;
            cfg_d.limit_act = cfg_q.limit_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cont_act     = cfg_q.conf_act[CONF_CONT];
    assign idle_lvl_act = cfg_q.conf_act[CONF_IDLE_LVL];
    assign idle_en_act  = cfg_q.conf_act[CONF_IDLE_EN];
    assign limit_act    = cfg_q.limit_act;
    assign irq_ena      = cfg_q.ena;
    assign clr_mask     = (we && addr == A_CLR) ? wdata[1:0] : 2'b00;
endmodule

// File: rtl/pulse_seq_tx.sv
module pulse_seq_tx #(
    parameter int MEM_WORDS = 48,
    parameter int PRESCALE  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_we,
    input  logic [$clog2(MEM_WORDS):0]   host_addr,
    input  logic [31:0]                  host_wdata,
    input  logic                         cfg_update,
    input  logic                         tx_start,
    input  logic                         rd_rst,
    output logic                         pin_out,
    output logic                         irq,
    output logic [1:0]                   irq_status
);
    import pst_pkg::*;

    localparam int PTR_W  = $clog2(MEM_WORDS);
    localparam int ADDR_W = PTR_W + 1;
    localparam int CNT_W  = PTR_W + 1;
    localparam logic [PTR_W-1:0] LAST_WORD = PTR_W'(MEM_WORDS - 1);

    typedef struct packed {
        logic                  run;
        logic [PTR_W-1:0]      ptr;
        logic                  hi;
        logic [ITEM_DUR_W-1:0] tcnt;
        logic [CNT_W-1:0]      words;
        logic [1:0]            st;
    } state_t;

    state_t state_d, state_q;

    logic                  tick;
    logic                  cont_act, idle_lvl_act, idle_en_act;
    logic [CNT_W-1:0]      limit_act;
    logic [1:0]            irq_ena, clr_mask;
    logic [ITEM_W-1:0]     cur_item;
    logic [ITEM_DUR_W-1:0] cur_dur, next_dur;
    logic [PTR_W-1:0]      nptr;
    logic                  nhi;
    logic                  mem_we;

    // address of the item after the current one
    assign nhi  = !state_q.hi;
    assign nptr = state_q.hi ? ((state_q.ptr == LAST_WORD) ? '0 : state_q.ptr + PTR_W'(1))
                             : state_q.ptr;

    assign mem_we = host_we && (host_addr < ADDR_W'(MEM_WORDS));

    pst_item_mem #(.WORDS(MEM_WORDS)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (host_addr[PTR_W-1:0]),
        .wdata   (host_wdata),
        .ra_a    (state_q.ptr),
        .ra_a_hi (state_q.hi),
        .item_a  (cur_item),
        .ra_b    (nptr),
        .ra_b_hi (nhi),
        .dur_b   (next_dur)
    );

    pst_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (host_we),
        .addr         (host_addr),
        .wdata        (host_wdata[CNT_W-1:0]),
        .update       (cfg_update),
        .cont_act     (cont_act),
        .idle_lvl_act (idle_lvl_act),
        .idle_en_act  (idle_en_act),
        .limit_act    (limit_act),
        .irq_ena      (irq_ena),
        .clr_mask     (clr_mask)
    );

    pst_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q.run),
        .clr   (tx_start || rd_rst),
        .tick  (tick)
    );

    assign cur_dur = cur_item[ITEM_DUR_W-1:0];

    logic             thr_ev, end_ev;
    logic [CNT_W-1:0] words_n;

    always_comb begin
        state_d = state_q;
        thr_ev  = 1'b0;
        end_ev  = 1'b0;
        words_n = state_q.hi ? state_q.words + CNT_W'(1) : state_q.words;

        if (tx_start) begin
            state_d.run   = 1'b1;
            state_d.ptr   = '0;
            state_d.hi    = 1'b0;
            state_d.tcnt  = '0;
            state_d.words = '0;
        end else if (rd_rst) begin
            state_d.ptr   = '0;
            state_d.hi    = 1'b0;
            state_d.tcnt  = '0;
            state_d.words = '0;
        end else if (state_q.run) begin
            if (cur_dur == '0) begin
                // only reachable if playback lands on a marker at word 0
                state_d.run = 1'b0;
                end_ev      = 1'b1;
            end else if (tick) begin
                if (state_q.tcnt + ITEM_DUR_W'(1) == cur_dur) begin
                    state_d.tcnt = '0;
                    if (state_q.hi && words_n == limit_act) thr_ev = 1'b1;
                    if (next_dur == '0) begin
                        if (cont_act) begin
                            state_d.ptr   = '0;
                            state_d.hi    = 1'b0;
                            state_d.words = '0;
                        end else begin
                            state_d.run = 1'b0;
                            end_ev      = 1'b1;
                        end
                    end else begin
                        state_d.ptr   = nptr;
                        state_d.hi    = nhi;
                        state_d.words = (state_q.hi && nptr == '0) ? '0 : words_n;
                    end
                end else begin
                    state_d.tcnt = state_q.tcnt + ITEM_DUR_W'(1);
                end
            end
        end

        state_d.st = (state_q.st & ~clr_mask);
        if (end_ev) state_d.st[ST_END] = 1'b1;
        if (thr_ev) state_d.st[ST_THR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pin_out    = state_q.run ? cur_item[ITEM_W-1] : (idle_en_act && idle_lvl_act);
    assign irq        = |(state_q.st & irq_ena);
    assign irq_status = state_q.st;
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
    parameter int MEM_WORDS = 48
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        host_we,
    input logic [$clog2(MEM_WORDS):0]  host_addr,
    input logic [1:0]                  host_wlow,
    input logic                        cfg_update,
    input logic                        tx_start,
    input logic                        rd_rst,
    input logic                        run_q,
    input logic [$clog2(MEM_WORDS)-1:0] ptr_q,
    input logic                        hi_q,
    input logic [1:0]                  status,
    input logic                        cont_act,
    input logic                        idle_lvl_act,
    input logic                        idle_en_act,
    input logic [$clog2(MEM_WORDS):0]  limit_act,
    input logic [14:0]                 cur_dur
);
    localparam int AW = $clog2(MEM_WORDS) + 1;
    localparam logic [AW-1:0] A_CLR = AW'((1 << (AW - 1)) + pst_pkg::OFS_CLR);

    a_r2_start_home: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (run_q && ptr_q == '0 && !hi_q));

    a_r4_cont_no_end: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cont_act && cur_dur != '0) |=> !$rose(status[0]));

    a_r5_stop_flags_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> status[0]);

    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_update |=> $stable({cont_act, idle_lvl_act, idle_en_act, limit_act}));

    a_r7_thr_on_word_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> ($past(hi_q) && $past(run_q)));

    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == A_CLR && host_wlow == 2'b11 && !run_q && !tx_start)
        |=> status == 2'b00);

    a_r9_rdrst_home: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rst && !tx_start) |=> (ptr_q == '0 && !hi_q));

    a_r11_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < ($clog2(MEM_WORDS))'(MEM_WORDS));
endmodule

bind pulse_seq_tx pst_checker #(.MEM_WORDS(MEM_WORDS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_wlow    (host_wdata[1:0]),
    .cfg_update   (cfg_update),
    .tx_start     (tx_start),
    .rd_rst       (rd_rst),
    .run_q        (state_q.run),
    .ptr_q        (state_q.ptr),
    .hi_q         (state_q.hi),
    .status       (state_q.st),
    .cont_act     (cont_act),
    .idle_lvl_act (idle_lvl_act),
    .idle_en_act  (idle_en_act),
    .limit_act    (limit_act),
    .cur_dur      (cur_dur)
);

// File: tb/pulse_seq_tx_tb.sv
module pulse_seq_tx_tb;
    localparam int P      = 5;
    localparam int WORDS  = 48;
    localparam int A_CONF = 64;
    localparam int A_LIM  = 65;
    localparam int A_ENA  = 66;
    localparam int A_CLR  = 67;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        cfg_update = 1'b0;
    logic        tx_start = 1'b0;
    logic        rd_rst = 1'b0;
    logic        pin_out, irq;
    logic [1:0]  irq_status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int lv [32];
    int du [32];

    always #2.5 clk = ~clk;

    pulse_seq_tx #(.MEM_WORDS(WORDS), .PRESCALE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .cfg_update(cfg_update), .tx_start(tx_start),
        .rd_rst(rd_rst), .pin_out(pin_out), .irq(irq), .irq_status(irq_status)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        host_we = 1'b1; host_addr = 7'(a); host_wdata = 32'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic upd();
        cfg_update = 1'b1;
        @(negedge clk);
        cfg_update = 1'b0;
    endtask

    task automatic go();
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    function automatic logic [15:0] item(input int l, input int d);
        return {l[0], d[14:0]};
    endfunction

    // items 0..n-1 from lv/du, then an end marker at index n
    task automatic load(input int n);
        for (int w = 0; w <= n / 2; w++) begin
            logic [15:0] lo, hi;
            lo = (2 * w < n)     ? item(lv[2*w], du[2*w])     : 16'h0000;
            hi = (2 * w + 1 < n) ? item(lv[2*w+1], du[2*w+1]) : 16'h0000;
            wr(w, {hi, lo});
        end
    endtask

    // checks every cycle of items first..last against the list
    task automatic expect_items(input int first, input int last, input string req);
        for (int i = first; i <= last; i++) begin
            int err = 0;
            int bad = 0;
            for (int c = 0; c < du[i] * P; c++) begin
                if (pin_out !== lv[i][0]) begin
                    err++;
                    bad = int'(pin_out);
                end
                @(negedge clk);
            end
            chk(err == 0, req, $sformatf("item %0d level over %0d cycles", i, du[i] * P),
                (err == 0) ? lv[i] : bad, lv[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R10)
        chk(pin_out == 1'b0, "R10", "reset pin", int'(pin_out), 0);
        chk(irq_status == 2'b00, "R10", "reset status", int'(irq_status), 0);
        chk(irq == 1'b0, "R10", "reset irq", int'(irq), 0);

        // one-shot sweep: R1 R2 R3 R5 R11
        for (int t = 0; t < 8; t++) begin
            int n = 3 + t;
            for (int i = 0; i < n; i++) begin
                du[i] = 2 + ((i * 3 + t) % 7);
                lv[i] = ((i + t) % 3 == 0) ? 1 : (i % 2);
            end
            load(n);
            go();
            expect_items(0, n - 1, "R1 R2 R3");
            chk(irq_status[0] == 1'b1, "R5", "end status after one-shot", int'(irq_status[0]), 1);
            chk(pin_out == 1'b0, "R5", "idle pin after one-shot", int'(pin_out), 0);
            wr(A_CLR, 3);
            chk(irq_status == 2'b00, "R8", "status cleared", int'(irq_status), 0);
        end

        // shadowed idle settings (R6 R10)
        wr(A_CONF, 6);
        chk(pin_out == 1'b0, "R6", "idle held before update", int'(pin_out), 0);
        upd();
        chk(pin_out == 1'b1, "R10", "idle level after update", int'(pin_out), 1);
        wr(A_CONF, 0);
        upd();
        chk(pin_out == 1'b0, "R10", "idle disabled", int'(pin_out), 0);

        // continuous mode (R4 R6 R5)
        du[0] = 3; lv[0] = 1;
        du[1] = 2; lv[1] = 0;
        du[2] = 4; lv[2] = 1;
        load(3);
        wr(A_CONF, 1);
        go();
        expect_items(0, 2, "R6");
        chk(irq_status[0] == 1'b1, "R6", "mode not active without update", int'(irq_status[0]), 1);
        wr(A_CLR, 3);
        upd();
        go();
        expect_items(0, 2, "R4");
        expect_items(0, 2, "R4");
        chk(irq_status[0] == 1'b0, "R4", "no end status on wrap", int'(irq_status[0]), 0);
        wr(A_CONF, 0);
        upd();
        repeat (42) @(negedge clk);
        chk(irq_status[0] == 1'b0 && pin_out == 1'b1, "R5", "still in last item",
            int'({irq_status[0], pin_out}), 1);
        @(negedge clk);
        chk(irq_status[0] == 1'b1, "R5", "end after final pass", int'(irq_status[0]), 1);
        chk(pin_out == 1'b0, "R5", "idle after final pass", int'(pin_out), 0);
        wr(A_CLR, 3);

        // threshold (R7 R8)
        for (int i = 0; i < 8; i++) begin
            du[i] = 2;
            lv[i] = i % 2;
        end
        load(8);
        wr(A_LIM, 2);
        wr(A_ENA, 2);
        upd();
        go();
        expect_items(0, 2, "R7");
        chk(irq_status[1] == 1'b0, "R7", "no threshold mid word", int'(irq_status[1]), 0);
        expect_items(3, 3, "R7");
        chk(irq_status[1] == 1'b1, "R7", "threshold after word 1", int'(irq_status[1]), 1);
        chk(irq == 1'b1, "R8", "irq on enabled threshold", int'(irq), 1);
        expect_items(4, 7, "R7");
        chk(irq_status == 2'b11, "R8", "both status sticky", int'(irq_status), 3);
        wr(A_CLR, 2);
        chk(irq_status == 2'b01, "R8", "clear threshold only", int'(irq_status), 1);
        chk(irq == 1'b0, "R8", "end not enabled", int'(irq), 0);
        wr(A_ENA, 3);
        chk(irq == 1'b1, "R8", "end enabled", int'(irq), 1);
        wr(A_CLR, 3);
        chk(irq == 1'b0, "R8", "irq after clear", int'(irq), 0);

        wr(A_LIM, 3);
        upd();
        go();
        expect_items(0, 4, "R7");
        chk(irq_status[1] == 1'b0, "R7", "new limit not yet hit", int'(irq_status[1]), 0);
        expect_items(5, 5, "R7");
        chk(irq_status[1] == 1'b1, "R7", "re-armed limit hit", int'(irq_status[1]), 1);
        expect_items(6, 7, "R7");
        wr(A_CLR, 3);

        // pointer reset mid-item (R9)
        du[0] = 4; lv[0] = 1;
        du[1] = 3; lv[1] = 0;
        du[2] = 5; lv[2] = 1;
        du[3] = 2; lv[3] = 0;
        load(4);
        go();
        expect_items(0, 0, "R9");
        repeat (5) @(negedge clk);
        rd_rst = 1'b1;
        @(negedge clk);
        rd_rst = 1'b0;
        expect_items(0, 3, "R9");
        chk(irq_status[0] == 1'b1, "R9", "end after restarted run", int'(irq_status[0]), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule